// File: doc/BRIEF.md
# Bridge Configuration Register Controller

This block holds the configuration registers that belong only to a bridge-type header: the three bus numbers and the secondary latency timer, the I/O, memory and prefetchable window base and limit registers with their upper extensions, the command word, the fixed primary and secondary status capability bits, the header type byte and the bridge control word. A configuration agent writes it through a dword-addressed port with per-byte enables. It reads it through a separate combinational read port.

Besides the register storage, the block produces two one-cycle strobes. One asks the secondary bus to reset, and fires only when software turns the secondary-reset control bit from 0 to 1. The other tells downstream address-decode logic that the command word or a forwarding window may have changed, so that it can rebuild its mappings. A preset input puts every window into the empty state, with each base above its limit, so that nothing is forwarded.

Top module: `bridge_cfg_regs`

## Requirements
- R1: While rst_n is low at a clock edge, the three bus numbers, the latency timer, the command word, the bridge control word and all upper window registers are cleared. The address bits of every base and limit register are cleared too. With default parameters the readback after reset is: dword 1 = 0x02200000, dword 3 = 0x00010000, dword 7 = 0x02200101, dword 9 = 0x00010001, and every other dword = 0.
- R2: The low nibble of the I/O base byte (0x1C) and of the I/O limit byte (0x1D) always reads 1 when IO_32BIT=1, and 0 otherwise. The low nibble of the prefetchable base (0x24) and limit (0x26) always reads 1 when PREF_64BIT=1, and 0 otherwise. Writes and presets never change these nibbles.
- R3: In a write, only the bytes whose enable bit is set are updated. Bit i of the byte enable selects data bits 8i+7..8i.
- R4: A disable_fwd_i cycle sets all address bits of the I/O, memory and prefetchable base registers to one. It clears all address bits of the three limit registers and zeroes both prefetchable upper registers (0x28, 0x2C). The read-only type bits are kept. Any write in the same cycle is dropped and raises no strobe. With default parameters, dword 8 then reads 0x0000FFF0 and dword 9 reads 0x0001FFF1.
- R5: sec_bus_rst_o is high for exactly one cycle, the cycle after an accepted write that sets bridge-control bit 6 (byte 0x3E, data bit 22 of dword 15 with byte enable 2) while that bit was 0.
- R6: Writing 1 to bridge-control bit 6 while it is already 1 produces no sec_bus_rst_o pulse.
- R7: map_update_o is high for one cycle, the cycle after an accepted write in which any enabled byte lies at address 0x04-0x05, 0x1C-0x1D or 0x20-0x33. Otherwise it stays low.
- R8: The status words at 0x06 and 0x1E read 0x0220 (66 MHz capable bit 5, fast back-to-back capable bit 9), and writes to them are ignored.
- R9: The header type byte at 0x0E reads 0x01, with bit 7 equal to the MULTI_FUNC parameter. The byte is read-only.
- R10: A read returns the current register contents combinationally and changes no state.
- R11: Writable bits are: command bits 10:0, bridge-control bits 11:0, all bytes of dwords 6, 10, 11 and 12 (dword 12 only with IO_32BIT=1, dwords 10-11 only with PREF_64BIT=1), and the address bits of dwords 7-9. Writes to any other dword are ignored, and those dwords read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disable_fwd_i | input | 1 | Preset all windows to the forward-nothing state |
| cfg_wr_en_i | input | 1 | Write strobe |
| cfg_wr_addr_i | input | ADDR_W | Dword index of the write |
| cfg_wr_data_i | input | 32 | Write data |
| cfg_wr_be_i | input | 4 | Byte enables of the write |
| cfg_rd_addr_i | input | ADDR_W | Dword index of the read |
| cfg_rd_data_o | output | 32 | Read data |
| sec_bus_rst_o | output | 1 | One-cycle secondary bus reset pulse |
| map_update_o | output | 1 | One-cycle mapping rebuild strobe |

## Verification
Every cycle, the assertions check that the read-only type nibbles never move and that a reset pulse only follows a 0-to-1 change of the control bit and never lasts two cycles. They also check that a preset leaves the windows empty, that reset leaves the bus numbers and control word clear, and that a mapping strobe only follows an accepted write. Other behaviour can only be shown by the bench's scenarios against its own register model: which byte lanes land, which address spans raise the mapping strobe and which do not, the values read from the fixed status and header bytes, dropped writes to foreign dwords, and a write that collides with a preset.

// File: rtl/bcr_pkg.sv
// Package: shared dword indices, constant fields and byte-merge helpers
// for the bridge configuration register controller.
// Assumes a 256-byte configuration space addressed by dword index.
package bcr_pkg;
    localparam int DW_CMD    = 1;
    localparam int DW_HDR    = 3;
    localparam int DW_BUS    = 6;
    localparam int DW_IOSTAT = 7;
    localparam int DW_MEM    = 8;
    localparam int DW_PREF   = 9;
    localparam int DW_PBU    = 10;
    localparam int DW_PLU    = 11;
    localparam int DW_IOU    = 12;
    localparam int DW_BCTL   = 15;

    localparam logic [15:0] STATUS_CAPS = 16'h0220;
    localparam logic [15:0] CMD_WMASK   = 16'h07FF;
    localparam logic [15:0] BCTL_WMASK  = 16'h0FFF;
    localparam int          BCTL_SBR    = 6;

    // Expand four byte enables to a 32-bit bit mask.
    function automatic logic [31:0] be_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] merge32(input logic [31:0] old_v,
                                            input logic [31:0] new_v,
                                            input logic [31:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

    function automatic logic [15:0] merge16(input logic [15:0] old_v,
                                            input logic [15:0] new_v,
                                            input logic [15:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

    typedef struct packed {
        logic [15:0] cmd;
        logic [31:0] bus;      // latency, subordinate, secondary, primary
        logic [15:0] io_bl;    // [15:8] limit, [7:0] base
        logic [31:0] mem_bl;   // [31:16] limit, [15:0] base
        logic [31:0] pref_bl;  // [31:16] limit, [15:0] base
        logic [31:0] pbu;
        logic [31:0] plu;
        logic [31:0] iou;      // [31:16] limit upper, [15:0] base upper
        logic [15:0] bctl;
    } bcr_regs_t;
endpackage

// File: rtl/bcr_reg_file.sv
// Register storage: applies reset defaults, the forward-nothing preset and
// byte-enabled writes with per-register write masks, and generates the
// secondary bus reset pulse on a 0->1 change of the control bit.
// Assumes preset has priority over a write in the same cycle.
module bcr_reg_file
    import bcr_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter bit IO_32BIT   = 1'b1,
    parameter bit PREF_64BIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disable_fwd,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_be,
    output bcr_regs_t         regs_o,
    output logic              sec_rst_o
);
    localparam logic [3:0]  IO_TYPE  = IO_32BIT ? 4'h1 : 4'h0;
    localparam logic [3:0]  PF_TYPE  = PREF_64BIT ? 4'h1 : 4'h0;
    localparam logic [7:0]  IO_B     = {4'h0, IO_TYPE};
    localparam logic [15:0] PF_W     = {12'h000, PF_TYPE};
    localparam logic [31:0] IOU_MASK = IO_32BIT ? 32'hFFFF_FFFF : 32'h0;
    localparam logic [31:0] PU_MASK  = PREF_64BIT ? 32'hFFFF_FFFF : 32'h0;

    bcr_regs_t   r;
    logic        sbr_q;
    logic [31:0] wm;
    logic        sbr_set;

    // Byte lane mask of the current write.
    assign wm = be_mask(wr_be);

    // Detect an accepted write that raises the secondary-reset control bit.
    assign sbr_set = wr_en && !disable_fwd && (wr_addr == ADDR_W'(DW_BCTL)) &&
                     wr_be[2] && wr_data[16+BCTL_SBR] && !r.bctl[BCTL_SBR];

    // Register update: reset, preset, then masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r.cmd     <= '0;
            r.bus     <= '0;
            r.io_bl   <= {IO_B, IO_B};
            r.mem_bl  <= '0;
            r.pref_bl <= {PF_W, PF_W};
            r.pbu     <= '0;
            r.plu     <= '0;
            r.iou     <= '0;
            r.bctl    <= '0;
            sbr_q     <= 1'b0;
        end else if (disable_fwd) begin
            r.io_bl   <= {4'h0, IO_TYPE, 4'hF, IO_TYPE};
            r.mem_bl  <= 32'h0000_FFF0;
            r.pref_bl <= {PF_W, 12'hFFF, PF_TYPE};
            r.pbu     <= '0;
            r.plu     <= '0;
            sbr_q     <= 1'b0;
        end else begin
            sbr_q <= sbr_set;
            if (wr_en) begin
                case (wr_addr)
                    ADDR_W'(DW_CMD):    r.cmd     <= merge16(r.cmd, wr_data[15:0], wm[15:0] & CMD_WMASK);
                    ADDR_W'(DW_BUS):    r.bus     <= merge32(r.bus, wr_data, wm);
                    ADDR_W'(DW_IOSTAT): r.io_bl   <= merge16(r.io_bl, wr_data[15:0], wm[15:0] & 16'hF0F0);
                    ADDR_W'(DW_MEM):    r.mem_bl  <= merge32(r.mem_bl, wr_data, wm & 32'hFFF0_FFF0);
                    ADDR_W'(DW_PREF):   r.pref_bl <= merge32(r.pref_bl, wr_data, wm & 32'hFFF0_FFF0);
                    ADDR_W'(DW_PBU):    r.pbu     <= merge32(r.pbu, wr_data, wm & PU_MASK);
                    ADDR_W'(DW_PLU):    r.plu     <= merge32(r.plu, wr_data, wm & PU_MASK);
                    ADDR_W'(DW_IOU):    r.iou     <= merge32(r.iou, wr_data, wm & IOU_MASK);
                    ADDR_W'(DW_BCTL):   r.bctl    <= merge16(r.bctl, wr_data[31:16], wm[31:16] & BCTL_WMASK);
                    default: ;
                endcase
            end
        end
    end

    assign regs_o    = r;
    assign sec_rst_o = sbr_q;

    AST_SBR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        sbr_q |-> (r.bctl[BCTL_SBR] && !$past(r.bctl[BCTL_SBR]))); // R5
    AST_SBR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sbr_q |=> !sbr_q); // R6
    AST_DISFWD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        disable_fwd |=> (r.mem_bl[31:20] == 12'h0 && r.mem_bl[15:4] == 12'hFFF &&
                         r.pref_bl[31:20] == 12'h0 && r.pref_bl[15:4] == 12'hFFF &&
                         r.pbu == 32'h0 && r.plu == 32'h0)); // R4
    AST_TYPE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (r.io_bl[3:0] == IO_TYPE && r.io_bl[11:8] == IO_TYPE &&
         r.pref_bl[3:0] == PF_TYPE && r.pref_bl[19:16] == PF_TYPE)); // R2
    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (r.bus == 32'h0 && r.bctl == 16'h0 && r.cmd == 16'h0)); // R1
endmodule

// File: rtl/bcr_span_detect.sv
// Mapping-update detector: flags an accepted write whose enabled bytes touch
// the command word, the I/O base/limit bytes or the window span 0x20-0x33,
// and registers the flag into a one-cycle strobe.
// Assumes the caller already removed writes dropped by the preset.
module bcr_span_detect #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_accept,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    output logic              map_update_o
);
    localparam int BA_W = ADDR_W + 2;

    logic [3:0] lane_hit;
    logic       upd_q;

    // Per-lane byte address range test.
    for (genvar i = 0; i < 4; i++) begin : g_lane
        logic [BA_W-1:0] ba;
        assign ba = {wr_addr, 2'(i)};
        assign lane_hit[i] = wr_be[i] &&
            ((ba >= BA_W'(8'h04) && ba <= BA_W'(8'h05)) ||
             (ba >= BA_W'(8'h1C) && ba <= BA_W'(8'h1D)) ||
             (ba >= BA_W'(8'h20) && ba <= BA_W'(8'h33)));
    end

    // Register the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= wr_accept && (lane_hit != 4'h0);
    end

    assign map_update_o = upd_q;

    AST_MAP_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |-> $past(wr_accept)); // R7
endmodule

// File: rtl/bcr_read_mux.sv
// Read path: assembles the addressed dword from stored registers and the
// constant status and header fields. Purely combinational, no side effects.
module bcr_read_mux
    import bcr_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter bit MULTI_FUNC = 1'b0
) (
    input  bcr_regs_t         regs_i,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam logic [7:0] HDR_TYPE = {MULTI_FUNC, 7'h01};

    // Select the dword for the read address.
    always_comb begin
        case (rd_addr)
            ADDR_W'(DW_CMD):    rd_data = {STATUS_CAPS, regs_i.cmd};
            ADDR_W'(DW_HDR):    rd_data = {8'h00, HDR_TYPE, 16'h0000};
            ADDR_W'(DW_BUS):    rd_data = regs_i.bus;
            ADDR_W'(DW_IOSTAT): rd_data = {STATUS_CAPS, regs_i.io_bl};
            ADDR_W'(DW_MEM):    rd_data = regs_i.mem_bl;
            ADDR_W'(DW_PREF):   rd_data = regs_i.pref_bl;
            ADDR_W'(DW_PBU):    rd_data = regs_i.pbu;
            ADDR_W'(DW_PLU):    rd_data = regs_i.plu;
            ADDR_W'(DW_IOU):    rd_data = regs_i.iou;
            ADDR_W'(DW_BCTL):   rd_data = {regs_i.bctl, 16'h0000};
            default:            rd_data = 32'h0;
        endcase
    end
endmodule

// File: rtl/bridge_cfg_regs.sv
// Top: bridge-header configuration registers with a byte-enabled dword write
// port, a combinational read port, a forward-nothing preset and two strobes.
// Assumes one write per cycle and synchronous active-low reset.
module bridge_cfg_regs
    import bcr_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter bit IO_32BIT   = 1'b1,
    parameter bit PREF_64BIT = 1'b1,
    parameter bit MULTI_FUNC = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disable_fwd_i,
    input  logic              cfg_wr_en_i,
    input  logic [ADDR_W-1:0] cfg_wr_addr_i,
    input  logic [31:0]       cfg_wr_data_i,
    input  logic [3:0]        cfg_wr_be_i,
    input  logic [ADDR_W-1:0] cfg_rd_addr_i,
    output logic [31:0]       cfg_rd_data_o,
    output logic              sec_bus_rst_o,
    output logic              map_update_o
);
    bcr_regs_t regs;
    logic      wr_accept;

    assign wr_accept = cfg_wr_en_i && !disable_fwd_i;

    bcr_reg_file #(
        .ADDR_W(ADDR_W), .IO_32BIT(IO_32BIT), .PREF_64BIT(PREF_64BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .disable_fwd(disable_fwd_i),
        .wr_en(cfg_wr_en_i), .wr_addr(cfg_wr_addr_i), .wr_data(cfg_wr_data_i),
        .wr_be(cfg_wr_be_i), .regs_o(regs), .sec_rst_o(sec_bus_rst_o)
    );

    bcr_span_detect #(.ADDR_W(ADDR_W)) u_span (
        .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept),
        .wr_addr(cfg_wr_addr_i), .wr_be(cfg_wr_be_i), .map_update_o(map_update_o)
    );

    bcr_read_mux #(.ADDR_W(ADDR_W), .MULTI_FUNC(MULTI_FUNC)) u_rd (
        .regs_i(regs), .rd_addr(cfg_rd_addr_i), .rd_data(cfg_rd_data_o)
    );
endmodule

// File: tb/bridge_cfg_regs_tb.sv
module bridge_cfg_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dis = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] wa = '0;
    logic [31:0]   wd = '0;
    logic [3:0]    be = '0;
    logic [AW-1:0] ra = '0;
    logic [31:0]   rd;
    logic          sbr, mupd;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_cfg_regs u_dut (
        .clk(clk), .rst_n(rst_n), .disable_fwd_i(dis), .cfg_wr_en_i(we),
        .cfg_wr_addr_i(wa), .cfg_wr_data_i(wd), .cfg_wr_be_i(be),
        .cfg_rd_addr_i(ra), .cfg_rd_data_o(rd), .sec_bus_rst_o(sbr),
        .map_update_o(mupd)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Writable bits per dword, from R11/R2/R8.
    function automatic logic [31:0] wmask(int a);
        case (a)
            1:  return 32'h0000_07FF;
            6:  return 32'hFFFF_FFFF;
            7:  return 32'h0000_F0F0;
            8:  return 32'hFFF0_FFF0;
            9:  return 32'hFFF0_FFF0;
            10, 11, 12: return 32'hFFFF_FFFF;
            15: return 32'h0FFF_0000;
            default: return 32'h0;
        endcase
    endfunction

    // Mapping spans from R7.
    function automatic bit span_hit(int a, logic [3:0] b);
        for (int i = 0; i < 4; i++) begin
            int ba = a * 4 + i;
            if (b[i] && ((ba >= 4 && ba <= 5) || (ba >= 28 && ba <= 29) ||
                         (ba >= 32 && ba <= 51))) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [31:0] lanes(logic [3:0] b);
        return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) model[i] = 32'h0;
        model[1] = 32'h0220_0000;
        model[3] = 32'h0001_0000;
        model[7] = 32'h0220_0101;
        model[9] = 32'h0001_0001;
    endtask

    task automatic readback(int a, string tag);
        ra = AW'(a);
        #1;
        chk(tag, rd, (a < 16) ? model[a] : 32'h0);
    endtask

    // One cycle of stimulus; starts and ends at a falling edge.
    task automatic op(int a, logic [31:0] d, logic [3:0] b, bit w, bit p, string tag);
        bit exp_sbr, exp_map;
        exp_sbr = w && !p && a == 15 && b[2] && d[22] && !model[15][22];
        exp_map = w && !p && span_hit(a, b);
        if (p) begin
            model[7]  = (model[7] & ~32'h0000_F0F0) | 32'h0000_00F0;
            model[8]  = 32'h0000_FFF0;
            model[9]  = 32'h0001_FFF1;
            model[10] = 32'h0;
            model[11] = 32'h0;
        end else if (w && a < 16) begin
            logic [31:0] m;
            m = wmask(a) & lanes(b);
            model[a] = (model[a] & ~m) | (d & m);
        end
        we = w; dis = p; wa = AW'(a); wd = d; be = b;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; dis = 1'b0;
        chk({tag, " sec_bus_rst"}, {31'h0, sbr}, {31'h0, exp_sbr});
        chk({tag, " map_update"}, {31'h0, mupd}, {31'h0, exp_map});
        readback(a, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset image, R8 status, R9 header, R2 type bits
        chk("R1 sec_bus_rst after reset", {31'h0, sbr}, 32'h0);
        chk("R1 map_update after reset", {31'h0, mupd}, 32'h0);
        for (int i = 0; i < 16; i++)
            readback(i, (i == 1 || i == 7) ? "R8" : (i == 3) ? "R9" : (i == 9) ? "R2" : "R1");

        // R2 type nibbles survive all-ones writes
        op(7, 32'hFFFF_FFFF, 4'hF, 1, 0, "R2 io base/limit");
        op(9, 32'hFFFF_FFFF, 4'hF, 1, 0, "R2 pref base/limit");
        // R8 status not writable
        op(1, 32'hFFFF_FFFF, 4'hC, 1, 0, "R8 status write");
        // R3 partial byte enables
        op(6, 32'hA1B2_C3D4, 4'h5, 1, 0, "R3 bytes 0 and 2");
        op(6, 32'h1122_3344, 4'h8, 1, 0, "R3 byte 3");
        // R11 foreign dword and header ignored
        op(5, 32'hDEAD_BEEF, 4'hF, 1, 0, "R11 foreign dword");
        op(3, 32'hFFFF_FFFF, 4'hF, 1, 0, "R9 header write");
        op(1, 32'hFFFF_FFFF, 4'h3, 1, 0, "R11 command mask");
        // R5 / R6 secondary reset edge
        op(15, 32'h0040_0000, 4'h4, 1, 0, "R5 first set");
        op(15, 32'h0040_0000, 4'h4, 1, 0, "R6 set again");
        op(15, 32'h0000_0000, 4'h4, 1, 0, "R5 clear");
        op(15, 32'h0040_0000, 4'h8, 1, 0, "R5 wrong lane");
        op(15, 32'hFFFF_0000, 4'hC, 1, 0, "R5 set with mask");
        // R7 span edges
        op(1, 32'h0, 4'h4, 1, 0, "R7 status byte only");
        op(1, 32'h0, 4'h1, 1, 0, "R7 command byte");
        op(7, 32'h0, 4'hC, 1, 0, "R7 secondary status bytes");
        op(12, 32'h0, 4'h8, 1, 0, "R7 last span byte");
        op(13, 32'h0, 4'hF, 1, 0, "R7 past span");
        op(8, 32'h0, 4'h0, 1, 0, "R7 no enables");
        // R4 preset colliding with a write
        op(8, 32'h1230_4560, 4'hF, 1, 1, "R4 preset wins");
        for (int i = 7; i < 12; i++) readback(i, "R4 preset image");
        // R10 reads have no effect
        readback(6, "R10 first read");
        readback(6, "R10 second read");
        @(negedge clk);
        chk("R10 no strobe from reads", {30'h0, sbr, mupd}, 32'h0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int a = $urandom_range(0, 17);
            bit p = ($urandom_range(0, 19) == 0);
            op(a, $urandom, 4'($urandom_range(0, 15)), 1, p, "R3 random");
            readback($urandom_range(0, 15), "R10 random read");
        end

        // R1 reset again after activity
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        for (int i = 0; i < 16; i++) readback(i, "R1 second reset");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule